// File: doc/BRIEF.md
# Lockable Watchdog / Interval Timer

This block is a free-running timer governed by one byte-wide control register on a plain register bus. The bus accepts either a whole-byte write or a single-bit write, in which a three-bit index and a one-bit value pick and set one bit. Reading the register returns its current value. Two bits of the register matter. The start bit clears the counter and begins counting. The mode bit selects between a periodic interval timer and a watchdog. Every other bit is tied to zero.

In interval mode the counter wraps at a parameterised terminal count and raises a one-cycle interrupt pulse on each wrap. In watchdog mode, reaching the terminal count raises a reset request. That request stays high until the hardware reset arrives. Software services the watchdog by writing the start bit to 1 again, which clears the counter. Both control bits can only be set by software. Once the timer is armed or placed in watchdog mode, only the hardware reset can stop it or reconfigure it.

Top module: `lockwdt_top`

## Requirements
- R1: While reset is applied and at the first clock after it is released, readback is 0x00, count is 0, and both the interrupt pulse and the reset request are low.
- R2: A byte write with bit 7 set sets the start bit and loads the count with 0 on that clock edge. After that, the count rises by one on every clock.
- R3: Bits 6, 5 and 3 down to 0 always read back as 0, whatever value was written to them.
- R4: Once the start bit (bit 7) or the mode bit (bit 4) holds 1, no byte write or single-bit write of 0 clears it. Only reset does.
- R5: Writing 1 to bit 7 while the timer is already running reloads the count with 0. This is the service action.
- R6: In interval mode (bit 4 = 0), the edge that finds the count at TERM_CNT-1 loads 0 and raises the interrupt for exactly one cycle, together with that count of 0. Counting then goes on.
- R7: In watchdog mode (bit 4 = 1), the edge that finds the count at TERM_CNT-1 raises the reset request and holds the count at TERM_CNT-1. The request stays high through any later write until reset.
- R8: A single-bit write with value 1 sets the indexed bit only if that index is 7 or 4. A value of 0, or any other index, leaves the readback unchanged.
- R9: Setting the mode bit while the timer runs does not clear the count. The count keeps rising by one.
- R10: A write of 1 to bit 7 on the same edge as the terminal count takes priority. The count goes to 0, with no interrupt and no reset request.
- R11: While the start bit is 0, the count stays 0 and neither output event occurs, even with the mode bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_bit_mode | input | 1 | 1 = single-bit write, 0 = whole-byte write |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_idx | input | 3 | Bit index for a single-bit write |
| bus_bit_val | input | 1 | Bit value for a single-bit write |
| bus_rdata | output | 8 | Control register readback |
| tick_irq | output | 1 | One-cycle interval interrupt pulse |
| wdt_reset_req | output | 1 | Sticky watchdog reset request |
| count | output | CNT_W | Current counter value |

## Verification
A lock bit that is lost or never set shows at `bus_rdata` in the cycle after the offending write. It then shows at `count`, which stops moving or stops being cleared, within one clock. A counter that is off by one, or that clears late, first appears as a mismatch in `count` on the very next edge. It then appears as an early or late `tick_irq` or `wdt_reset_req` once the terminal count is reached, at most TERM_CNT cycles later. A restart or terminal-count priority that is wrong shows at `count`, and at the event outputs, on the edge right after the colliding write.

// File: rtl/lockwdt_pkg.sv
// Package: shared constants and types for the lockable watchdog timer.
// Assumes an 8-bit control register with exactly two writable bits.
package lockwdt_pkg;

    localparam int unsigned CTRL_W   = 8;
    localparam int unsigned IDX_W    = $clog2(CTRL_W);
    localparam int unsigned RUN_POS  = 7;
    localparam int unsigned MODE_POS = 4;
    localparam int unsigned NUM_CTRL = 2;

    // Mask of the bits software may set
    localparam logic [CTRL_W-1:0] CTRL_MASK = (CTRL_W'(1) << RUN_POS) | (CTRL_W'(1) << MODE_POS);

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_WATCHDOG = 1'b1
    } tmr_mode_e;

    // Position of control slot k (0 = start bit, 1 = mode bit)
    function automatic int unsigned ctrl_pos(input int unsigned k);
        return (k == 0) ? RUN_POS : MODE_POS;
    endfunction

endpackage

// File: rtl/lockwdt_busdec.sv
// Module: lockwdt_busdec
// Turns one bus write (byte-wide or single-bit) into per-control-bit "set"
// requests. It never produces a clear request: the register only locks upward.
// Assumes bus_wr is high for exactly one cycle per write.
module lockwdt_busdec
    import lockwdt_pkg::*;
(
    input  logic              bus_wr,
    input  logic              bus_bit_mode,
    input  logic [CTRL_W-1:0] bus_wdata,
    input  logic [IDX_W-1:0]  bus_bit_idx,
    input  logic              bus_bit_val,
    output logic [NUM_CTRL-1:0] set_req
);

    // Sink for data bits that are hard-wired to zero
    logic unused_wdata;
    assign unused_wdata = ^(bus_wdata & ~CTRL_MASK);

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_slot
        localparam int unsigned POS = ctrl_pos(k);
        logic byte_hit;
        logic bit_hit;

        // Per slot: a byte write with a 1 in this position, or a bit write of 1 to this index
        always_comb begin
            byte_hit   = bus_wdata[POS];
            bit_hit    = (bus_bit_idx == IDX_W'(POS)) && bus_bit_val;
            set_req[k] = bus_wr && (bus_bit_mode ? bit_hit : byte_hit);
        end
    end

endmodule

// File: rtl/lockwdt_modereg.sv
// Module: lockwdt_modereg
// Holds the start and mode bits with set-only semantics and builds the readback.
// A write of 1 to the start bit also produces a one-cycle restart strobe,
// whether or not the bit was already set.
// Assumes a synchronous active-low reset is the only way to clear the bits.
module lockwdt_modereg
    import lockwdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CTRL-1:0] set_req,
    output logic                run,
    output tmr_mode_e           mode,
    output logic                restart,
    output logic [CTRL_W-1:0]   rdata
);

    logic run_q;
    logic mode_q;

    // Set-only register: a request may raise a bit, only reset lowers it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            run_q  <= run_q  | set_req[0];
            mode_q <= mode_q | set_req[1];
        end
    end

    // Restart strobe follows any write of 1 to the start bit
    assign restart = set_req[0];
    assign run     = run_q;
    assign mode    = tmr_mode_e'(mode_q);

    // Readback: only the two control positions are live, the rest read 0
    always_comb begin
        rdata           = '0;
        rdata[RUN_POS]  = run_q;
        rdata[MODE_POS] = mode_q;
    end

    AST_RUN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q); // R4
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> mode_q); // R4
    AST_RDATA_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~CTRL_MASK) == '0); // R3

endmodule

// File: rtl/lockwdt_counter.sv
// Module: lockwdt_counter
// Up-counter from 0 to TERM_CNT-1. A restart clears it, and restart wins over
// everything else. In interval mode it wraps at the terminal count. In watchdog
// mode it holds there. Assumes TERM_CNT >= 2 and TERM_CNT fits in CNT_W bits.
module lockwdt_counter
    import lockwdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned TERM_CNT = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tmr_mode_e        mode,
    input  logic             restart,
    output logic             at_term,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TERM_M1 = CNT_W'(TERM_CNT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Terminal-count detector
    assign at_term = (cnt_q == TERM_M1);

    // Count update: restart clears, a run advances or wraps, watchdog holds at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (!at_term) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (mode == MODE_INTERVAL) begin
                cnt_q <= '0;
            end
        end
    end

    assign cnt = cnt_q;

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R5
    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (cnt_q == '0)); // R11
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM_M1); // R6

endmodule

// File: rtl/lockwdt_event.sv
// Module: lockwdt_event
// Produces the registered output events at the terminal count: a one-cycle
// interval interrupt, or a sticky watchdog reset request. A restart in the same
// cycle suppresses both. Assumes at_term comes straight from the counter state.
module lockwdt_event
    import lockwdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  tmr_mode_e mode,
    input  logic      restart,
    input  logic      at_term,
    output logic      tick_irq,
    output logic      reset_req
);

    logic fire;
    logic irq_q;
    logic req_q;

    // Terminal event is live only while running and not pre-empted by a restart
    assign fire = run && at_term && !restart;

    // Interrupt pulse: high for the single cycle after an interval wrap
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire && (mode == MODE_INTERVAL);
    end

    // Reset request: raised on a watchdog expiry, held until hardware reset
    always_ff @(posedge clk) begin
        if (!rst_n)                              req_q <= 1'b0;
        else if (fire && mode == MODE_WATCHDOG)  req_q <= 1'b1;
    end

    assign tick_irq  = irq_q;
    assign reset_req = req_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R6
    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> req_q); // R7
    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q && $rose(req_q))); // R7

endmodule

// File: rtl/lockwdt_top.sv
// Module: lockwdt_top
// Lockable watchdog/interval timer: the bus decode feeds the set-only control
// register, which drives the counter and the event generator.
// Assumes clk is the already-prescaled timer clock and that the reset request
// is turned into a hardware reset outside this block.
module lockwdt_top
    import lockwdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned TERM_CNT = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_bit_mode,
    input  logic [CTRL_W-1:0] bus_wdata,
    input  logic [IDX_W-1:0]  bus_bit_idx,
    input  logic              bus_bit_val,
    output logic [CTRL_W-1:0] bus_rdata,
    output logic              tick_irq,
    output logic              wdt_reset_req,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] TERM_M1 = CNT_W'(TERM_CNT - 1);

    logic [NUM_CTRL-1:0] set_req;
    logic                run;
    tmr_mode_e           mode;
    logic                restart;
    logic                at_term;

    lockwdt_busdec u_busdec (
        .bus_wr       (bus_wr),
        .bus_bit_mode (bus_bit_mode),
        .bus_wdata    (bus_wdata),
        .bus_bit_idx  (bus_bit_idx),
        .bus_bit_val  (bus_bit_val),
        .set_req      (set_req)
    );

    lockwdt_modereg u_modereg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .run     (run),
        .mode    (mode),
        .restart (restart),
        .rdata   (bus_rdata)
    );

    lockwdt_counter #(
        .CNT_W    (CNT_W),
        .TERM_CNT (TERM_CNT)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mode    (mode),
        .restart (restart),
        .at_term (at_term),
        .cnt     (count)
    );

    lockwdt_event u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mode      (mode),
        .restart   (restart),
        .at_term   (at_term),
        .tick_irq  (tick_irq),
        .reset_req (wdt_reset_req)
    );

    AST_IRQ_WITH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> (count == '0)); // R6
    AST_EXPIRE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_reset_req) |-> (count == TERM_M1)); // R7
    AST_RESTART_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !wdt_reset_req) |=> (!tick_irq && !wdt_reset_req)); // R10

endmodule

// File: tb/test_lockwdt_top.sv
// Bench: a behavioural model, compared on every clock, plus directed checks.
module test_lockwdt_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int TERM       = 10;
    localparam int WD_LIMIT   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_bit_mode = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic [2:0]       bus_bit_idx = '0;
    logic             bus_bit_val = 1'b0;
    logic [7:0]       bus_rdata;
    logic             tick_irq;
    logic             wdt_reset_req;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Behavioural model state
    int m_run = 0, m_mode = 0, m_cnt = 0, m_irq = 0, m_req = 0;

    lockwdt_top #(.CNT_W(CNT_W), .TERM_CNT(TERM)) i_lockwdt_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bit_mode(bus_bit_mode),
        .bus_wdata(bus_wdata), .bus_bit_idx(bus_bit_idx), .bus_bit_val(bus_bit_val),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq), .wdt_reset_req(wdt_reset_req),
        .count(count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Model update from the requirements, on each rising edge
    always @(posedge clk) begin
        int rs, sm;
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_cnt = 0; m_irq = 0; m_req = 0;
        end else begin
            rs = bus_wr && (bus_bit_mode ? (bus_bit_idx == 7 && bus_bit_val) : bus_wdata[7]);
            sm = bus_wr && (bus_bit_mode ? (bus_bit_idx == 4 && bus_bit_val) : bus_wdata[4]);
            m_irq = 0;
            if (rs) m_cnt = 0;
            else if (m_run != 0) begin
                if (m_cnt == TERM-1) begin
                    if (m_mode != 0) m_req = 1;
                    else begin m_cnt = 0; m_irq = 1; end
                end else m_cnt = m_cnt + 1;
            end
            if (rs) m_run = 1;
            if (sm) m_mode = 1;
        end
    end

    // Per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        check("R2 count vs model", int'(count), m_cnt);
        check("R6 tick_irq vs model", int'(tick_irq), m_irq);
        check("R7 wdt_reset_req vs model", int'(wdt_reset_req), m_req);
        check("R4 rdata vs model", int'(bus_rdata), (m_run << 7) | (m_mode << 4));
    end

    // Watchdog on the bench itself
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            checks++; fails++;
            $display("FAIL bench watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // All tasks start and end on a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic byte_wr(input logic [7:0] b);
        bus_wr = 1'b1; bus_bit_mode = 1'b0; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bit_wr(input logic [2:0] idx, input logic val);
        bus_wr = 1'b1; bus_bit_mode = 1'b1; bus_bit_idx = idx; bus_bit_val = val;
        @(negedge clk);
        bus_wr = 1'b0; bus_bit_mode = 1'b0; bus_bit_idx = '0; bus_bit_val = 1'b0;
    endtask

    task automatic wait_top();
        while (int'(count) != TERM-1) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        check("R1 rdata after reset", int'(bus_rdata), 0);
        check("R1 count after reset", int'(count), 0);
        check("R1 irq after reset", int'(tick_irq), 0);
        check("R1 req after reset", int'(wdt_reset_req), 0);
    endtask

    initial begin
        int c;
        @(negedge clk);
        do_reset();
        idle(5);
        check("R11 idle count", int'(count), 0);

        // Interval mode, with junk in the zero bits
        byte_wr(8'hAF);
        check("R2 count cleared on start", int'(count), 0);
        check("R3 junk bits read zero", int'(bus_rdata), 8'h80);
        idle(1);
        check("R2 count advances", int'(count), 1);
        wait_top();
        idle(1);
        check("R6 irq on wrap", int'(tick_irq), 1);
        check("R6 count wraps to 0", int'(count), 0);
        idle(1);
        check("R6 irq one cycle", int'(tick_irq), 0);
        idle(3);
        byte_wr(8'h80);
        check("R5 service clears count", int'(count), 0);
        byte_wr(8'h00);
        check("R4 byte zero keeps start bit", int'(bus_rdata), 8'h80);
        bit_wr(3'd7, 1'b0);
        check("R8 bit write 0 ignored", int'(bus_rdata), 8'h80);
        bit_wr(3'd5, 1'b1);
        check("R8 other index ignored", int'(bus_rdata), 8'h80);

        // Restart colliding with terminal count
        wait_top();
        byte_wr(8'h80);
        check("R10 restart wins count", int'(count), 0);
        check("R10 no irq", int'(tick_irq), 0);

        // Switch to watchdog while running
        idle(4);
        c = int'(count);
        bit_wr(3'd4, 1'b1);
        check("R9 mode set keeps count", int'(count), c + 1);
        check("R8 bit write sets mode", int'(bus_rdata), 8'h90);
        idle(3);
        byte_wr(8'h80);
        check("R5 watchdog service", int'(count), 0);
        check("R5 no request after service", int'(wdt_reset_req), 0);
        bit_wr(3'd4, 1'b0);
        check("R4 mode locked", int'(bus_rdata), 8'h90);
        wait_top();
        idle(1);
        check("R7 request raised", int'(wdt_reset_req), 1);
        check("R7 count held", int'(count), TERM-1);
        byte_wr(8'h00);
        idle(3);
        check("R7 request sticky", int'(wdt_reset_req), 1);
        check("R4 bits locked", int'(bus_rdata), 8'h90);
        byte_wr(8'h80);
        check("R7 request survives service", int'(wdt_reset_req), 1);

        // Back to reset; mode without start
        do_reset();
        bit_wr(3'd4, 1'b1);
        check("R11 mode only readback", int'(bus_rdata), 8'h10);
        idle(3*TERM);
        check("R11 count stays 0", int'(count), 0);
        check("R11 no request", int'(wdt_reset_req), 0);
        byte_wr(8'hFF);
        check("R3 all ones reads 0x90", int'(bus_rdata), 8'h90);
        idle(TERM + 2);
        check("R7 expiry from byte start", int'(wdt_reset_req), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule